// File: doc/BRIEF.md
# Signed Fixed-Point Multiply and Store Stage

This block multiplies two signed two's complement operands of `W` bits each and keeps the full `2W`-bit product. It then forms the `W`-bit word that software would store, and the way it forms that word depends on how the operands are interpreted. When both operands are integers, the word is the low half of the product. When at least one operand is a fraction, the word is the high half after a one-bit left shift. That shift removes the duplicated sign bit that a fractional product carries. Every output is registered, so the stored word, the product and a flag appear one clock after an input strobe.

In the fractional formats the word can be rounded or truncated. Rounding adds the bit that lies just below the stored field. The left shift and the rounding both act outside the product register, so they can overflow even though the product itself cannot. When that happens the stored word saturates to the largest value of the correct sign, and the flag is raised. In integer format the flag reports that the product does not fit in `W` signed bits.

Top module: `fxp_mul_store`

## Requirements
- R1: `product` holds the exact signed `2W`-bit product of `op_a` and `op_b` captured on the most recent edge at which `in_valid` was high.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge, giving a latency of exactly one cycle.
- R3: With `fmt` = 2'b00 (integer × integer), `result` is product bits [W-1:0], with no shift, and `round_en` has no effect.
- R4: With `fmt` = 2'b00, `ovf` is 1 exactly when the product lies outside [-2^(W-1), 2^(W-1)-1]. `result` still holds the low bits unchanged.
- R5: With `fmt` = 2'b01 (fraction × integer), 2'b10 (fraction × fraction) or 2'b11 (treated the same as 2'b10), and `round_en` = 0, `result` is product bits [2W-2:W-1], which is the high half after a one-bit left shift, provided no overflow occurs.
- R6: In the fractional formats with `round_en` = 1, product bit W-2 (the bit just below the stored field after the shift) is added to the field before it is stored.
- R7: In the fractional formats, when the shift changes the sign, or when the rounding carries past the top of the range, `result` saturates to 2^(W-1)-1 for a positive product or to -2^(W-1) for a negative product, and `ovf` = 1. Otherwise `ovf` = 0. For example, -1 × -1 in Q15 stores 16'h7FFF with `ovf` = 1.
- R8: While `in_valid` is low, `product`, `result` and `ovf` keep their previous values whatever the other inputs do.
- R9: During reset (`rst_n` low), `out_valid`, `product`, `result` and `ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | W | First signed operand |
| op_b | input | W | Second signed operand |
| fmt | input | 2 | Operand formats: 00 integer×integer, 01 fraction×integer, 10/11 fraction×fraction |
| round_en | input | 1 | Round instead of truncate in the fractional formats |
| out_valid | output | 1 | Outputs refreshed this cycle |
| product | output | 2W | Full signed product |
| result | output | W | Stored word |
| ovf | output | 1 | Range exceeded (integer format) or saturation applied (fractional formats) |

## Verification
All state in this block is a single output register, so any fault in the product path, the field selection, the round carry or the saturation choice shows up in the very cycle after the operands are strobed. A reference model in the bench predicts every port on every clock. The bench also aims at the spots where a one-bit slip stays hidden in most operands: the most negative operand squared, products whose discarded bit is 1, and products just past the integer range. A register that loses its hold shows up on cycles where `in_valid` is low and the operands keep changing.

// File: rtl/fxp_mul_store.sv
module fxp_mul_store #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [1:0]        fmt,
  input  logic              round_en,
  output logic              out_valid,
  output logic [2*W-1:0]    product,
  output logic [W-1:0]      result,
  output logic              ovf
);

  localparam int PW = 2 * W;
  localparam logic [1:0] FMT_INT = 2'b00;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [PW-1:0] a_x, b_x, prod_c;
  logic [W-1:0] hi_field, sat_word, frac_word, word_c;
  logic [W:0]   rsum;
  logic         rbit, shift_ovf, rnd_ovf, frac_ovf, int_ovf, ovf_c;

  assign a_x    = PW'($signed(op_a));
  assign b_x    = PW'($signed(op_b));
  assign prod_c = a_x * b_x;

  assign int_ovf = (|prod_c[PW-1:W-1]) & ~(&prod_c[PW-1:W-1]);

  assign hi_field  = prod_c[PW-2:W-1];
  assign rbit      = round_en & prod_c[W-2];
  assign rsum      = {hi_field[W-1], hi_field} + {{W{1'b0}}, rbit};
  assign shift_ovf = prod_c[PW-1] ^ prod_c[PW-2];
  assign rnd_ovf   = rsum[W] ^ rsum[W-1];
  assign frac_ovf  = shift_ovf | rnd_ovf;
  assign sat_word  = prod_c[PW-1] ? NEG_MIN : POS_MAX;
  assign frac_word = frac_ovf ? sat_word : rsum[W-1:0];

  assign word_c = (fmt == FMT_INT) ? prod_c[W-1:0] : frac_word;
  assign ovf_c  = (fmt == FMT_INT) ? int_ovf : frac_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        product <= prod_c;
        result  <= word_c;
        ovf     <= ovf_c;
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(product) && $stable(result) && $stable(ovf)));

  p_int_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt) == FMT_INT) |-> result == product[W-1:0]);

  p_int_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt) == FMT_INT && !ovf) |-> (product[PW-1:W] == {W{product[W-1]}}));

  p_sat_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf && $past(fmt) != FMT_INT) |-> (result == POS_MAX || result == NEG_MIN));

  p_sat_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf && $past(fmt) != FMT_INT) |-> result[W-1] == product[PW-1]);

  p_trunc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ovf && $past(fmt) != FMT_INT && !$past(round_en)) |-> result == product[PW-2:W-1]);

endmodule

// File: tb/fxp_mul_store_bench.sv
module fxp_mul_store_bench;
  localparam int W = 16;
  localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (W-1));

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, round_en = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [1:0] fmt = 2'b00;
  logic out_valid, ovf;
  logic [2*W-1:0] product;
  logic [W-1:0] result;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic e_v = 0, e_o = 0;
  logic [2*W-1:0] e_p = '0;
  logic [W-1:0] e_r = '0;
  logic [1:0] e_fmt = 2'b00;
  logic e_hold = 0, e_rst = 1;

  always #10 clk = ~clk;

  fxp_mul_store #(.W(W)) u_fxp_mul_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .fmt(fmt), .round_en(round_en), .out_valid(out_valid), .product(product),
    .result(result), .ovf(ovf));

  always @(posedge clk) begin
    if (!rst_n) begin
      e_v = 0; e_p = '0; e_r = '0; e_o = 0; e_rst = 1; e_hold = 0;
    end else begin
      e_rst = 0;
      e_v = in_valid;
      e_hold = !in_valid;
      if (in_valid) begin
        longint p, s, hi, v;
        p = longint'($signed(op_a)) * longint'($signed(op_b));
        e_p = p[2*W-1:0];
        e_fmt = fmt;
        if (fmt == 2'b00) begin
          e_r = p[W-1:0];
          e_o = (p > MAXV) || (p < MINV);
        end else begin
          s = p * 2;
          hi = s >>> W;
          v = hi + ((round_en && ((s >>> (W-1)) & 1) != 0) ? 1 : 0);
          if (v > MAXV) begin v = MAXV; e_o = 1; end
          else if (v < MINV) begin v = MINV; e_o = 1; end
          else e_o = 0;
          e_r = v[W-1:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      string tag;
      n_cmp++;
      if (out_valid !== e_v || product !== e_p || result !== e_r || ovf !== e_o) begin
        n_bad++;
        if (e_rst) tag = "R9";
        else if (out_valid !== e_v) tag = "R2";
        else if (e_hold) tag = "R8";
        else if (product !== e_p) tag = "R1";
        else if (e_fmt == 2'b00) tag = (result !== e_r) ? "R3" : "R4";
        else if (e_o || ovf) tag = "R7";
        else tag = "R5/R6";
        $display("FAIL %s: got v=%0b p=%h r=%h o=%0b, expected v=%0b p=%h r=%h o=%0b",
                 tag, out_valid, product, result, ovf, e_v, e_p, e_r, e_o);
      end
    end
  end

  task automatic put(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [1:0] f, input logic r, input logic v);
    @(negedge clk);
    op_a = a; op_b = b; fmt = f; round_en = r; in_valid = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);          // R9 reset state checked each cycle
    rst_n = 1'b1;
    put(16'd100, 16'd200, 2'b00, 1'b0, 1'b1);   // R3 small integers
    put(16'd300, 16'd300, 2'b00, 1'b1, 1'b1);   // R4 out of range, R3 round ignored
    put(16'hFFFD, 16'd5, 2'b00, 1'b0, 1'b1);    // R3 negative
    put(16'h8000, 16'h8000, 2'b00, 1'b0, 1'b1); // R4 extreme
    put(16'h4000, 16'h4000, 2'b10, 1'b0, 1'b1); // R5 0.5*0.5
    put(16'h8000, 16'h8000, 2'b10, 1'b0, 1'b1); // R7 -1*-1 saturates
    put(16'h8000, 16'h8000, 2'b11, 1'b1, 1'b1); // R7 alias format
    put(16'd1, 16'h4000, 2'b10, 1'b0, 1'b1);    // R5 truncates to 0
    put(16'd1, 16'h4000, 2'b10, 1'b1, 1'b1);    // R6 rounds up to 1
    put(16'hFFFF, 16'h4000, 2'b10, 1'b1, 1'b1); // R6 negative rounding
    put(16'h6000, 16'd3, 2'b01, 1'b0, 1'b1);    // R5 fraction*integer
    put(16'h8000, 16'h8001, 2'b01, 1'b1, 1'b1); // R6/R7 near top
    for (int i = 0; i < 8; i++)                 // R8 hold with changing inputs
      put(16'(i * 4099), 16'(i * 77), 2'(i), 1'(i), 1'b0);
    for (int i = 0; i < 600; i++)               // R1 R2 random mix
      put(16'($urandom), 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom % 4 != 0));
    put(16'd0, 16'd0, 2'b00, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R2: watchdog expired, got no finish, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule